// File: doc/BRIEF.md
# Transparent Serial Character Receiver

This block turns a raw serial bit stream into parallel characters. A bit is taken on each rising edge of a bit clock while reception is enabled. Once the programmed number of bits has arrived, the character goes out as a 16-bit word with a valid/ready handshake. Characters shorter than 16 bits are padded with zeros in the upper bits. A mode input selects the bit order: the first bit received is either the least significant bit or the most significant bit of the character.

Storage is two characters deep: the shift register that assembles the next character, plus one holding register that presents the finished one. If a new character completes while the holding register still holds an unread character, the new one replaces it and the old one is lost. The replacement character carries an overrun flag. When overrun events are enabled, a one-cycle receive event pulses. Reception goes on without any restart command. A start pulse marks the first character after reception is enabled, so that a downstream agent can begin setting up its buffer.

Top module: `serial_char_rx`

## Requirements
- R1: A length code N from 3 to 15 gives characters of N+1 bits. Codes 0 to 2 are treated as code 3, which gives 4-bit characters.
- R2: Output bits at and above the character length are always zero.
- R3: When reverse is 0, the first received bit is bit 0 of the output word and later bits fill bits 1, 2 and so on.
- R4: When reverse is 1, the first received bit is bit N of the output word (the character MSB) and the last received bit is bit 0.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_overrun stay unchanged, unless a newer character overruns the held one.
- R6: A character can be assembled while the previous one waits in the holding register. If the held one is read before the new one completes, both are delivered in order and neither carries the overrun flag.
- R7: If a character completes while the holding register is full and not being read in that cycle, the new character replaces the held one and is presented with out_overrun = 1. A character that loads into an empty register, or into one being read in the same cycle, has out_overrun = 0.
- R8: Each overrun pulses rx_event for one cycle when evt_en is 1. When evt_en is 0, rx_event stays low.
- R9: After an overrun, the next characters are received correctly with no command or re-enable.
- R10: While rx_en is 0, no bits are sampled and any partly received character is discarded. After rx_en returns to 1, assembly starts again from the first bit.
- R11: buf_start pulses for one cycle when the first character completes after reset or after rx_en rises. It does not pulse again until rx_en has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock, synchronous to clk; data is taken on its rising edge |
| rx_bit | input | 1 | Serial data bit |
| rx_en | input | 1 | Receive enable |
| len_code | input | 4 | Character length code (length = code + 1) |
| rev_order | input | 1 | 1 = first bit is the MSB |
| evt_en | input | 1 | Enable for the overrun receive event |
| out_data | output | 16 | Received character, zero-extended |
| out_overrun | output | 1 | Set when this character replaced an unread one |
| out_valid | output | 1 | Holding register holds a character |
| out_ready | input | 1 | Consumer accepts the character |
| rx_event | output | 1 | One-cycle overrun event pulse |
| buf_start | output | 1 | One-cycle first-character pulse |

## Verification
Every length code from 3 to 15 is swept in both bit orders with three values: all ones, a mixed pattern, and its complement. Asymmetric patterns show whether the bit order or the bit positions are wrong, and all ones shows whether the upper zero padding is correct. Further cases cover the following:
- a clamped length code;
- a consumer that stalls, to show that the data is held;
- a read that happens while the next character is still arriving, compared with no read at all, to separate two-deep storage from overrun;
- overruns with the event enabled and disabled;
- a partial character cut off by dropping the enable;
- a re-enable, to show that the start pulse fires once for each enable period.

// File: rtl/serial_char_rx_pkg.sv
// Package: shared widths and the holding-register entry type for the
// serial character receiver. Assumes a power-of-two word width.
package serial_char_rx_pkg;
    localparam int WORD_W   = 16;
    localparam int CODE_W   = $clog2(WORD_W);
    localparam int MIN_CODE = 3;

    typedef logic [WORD_W-1:0] word_t;

    // One held character plus its status.
    typedef struct packed {
        word_t data;
        logic  overrun;
    } held_t;
endpackage

// File: rtl/rx_edge_detect.sv
// Module: rx_edge_detect
// Produces a single-cycle sample strobe on each rising edge of a bit clock.
// Assumes bit_clk is already synchronous to clk and each level lasts at
// least one clk cycle. The strobe is gated by the enable.
module rx_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_clk,
    output logic sample
);
    logic bit_q;

    // Remember the previous bit clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_clk;
    end

    // A rise is a high level now after a low level one cycle ago.
    always_comb sample = en & bit_clk & ~bit_q;
endmodule

// File: rtl/rx_shifter.sv
// Module: rx_shifter
// Assembles one character from sampled bits. Bits go in LSB-first, or
// MSB-first when rev is set. When the last bit arrives, the masked word is
// registered with a one-cycle done pulse. Assumes len_code and rev stay
// stable during a character. A low enable clears the bit count.
module rx_shifter #(
    parameter int DW       = 16,
    parameter int CW       = 4,
    parameter int MIN_CODE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sample,
    input  logic          bit_in,
    input  logic [CW-1:0] len_code,
    input  logic          rev,
    output logic          done,
    output logic [DW-1:0] word
);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_CODE);
    localparam logic [CW-1:0] TOP_C = CW'(DW - 1);

    logic [CW-1:0] len_eff;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] nxt;
    logic [DW-1:0] mask;

    // Clamp illegal short codes and form the length mask.
    always_comb begin
        len_eff = (len_code < MIN_C) ? MIN_C : len_code;
        mask    = {DW{1'b1}} >> (TOP_C - len_eff);
    end

    // Next shift register value for the bit being taken.
    always_comb begin
        if (rev) begin
            nxt = {shreg[DW-2:0], bit_in};
        end else begin
            nxt = (cnt == '0) ? '0 : shreg;
            nxt[cnt] = bit_in;
        end
    end

    // Bit counter, shift register and completed-word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (sample) begin
                shreg <= nxt;
                if (cnt == len_eff) begin
                    cnt  <= '0;
                    done <= 1'b1;
                    word <= nxt & mask;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10: a disabled receiver restarts from the first bit.
    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0) && !done);

    // R1: a completion is a single-cycle pulse.
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/rx_hold.sv
// Module: rx_hold
// Single holding register between the shifter and the consumer. Presents
// the data with valid/ready. A character arriving while the register is
// full and not being read replaces it and is flagged as an overrun. Also
// generates the overrun event and the first-character start pulse.
module rx_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          evt_en,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          ready,
    output logic [DW-1:0] data,
    output logic          overrun,
    output logic          valid,
    output logic          event_o,
    output logic          start_o
);
    logic pop;
    logic clash;
    logic first_seen;

    // Handshake and collision decode.
    always_comb begin
        pop   = valid & ready;
        clash = load & valid & ~ready;
    end

    // Holding register contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else if (load) begin
            valid   <= 1'b1;
            data    <= load_word;
            overrun <= clash;
        end else if (pop) begin
            valid   <= 1'b0;
        end
    end

    // Overrun event and first-character start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_o    <= 1'b0;
            start_o    <= 1'b0;
            first_seen <= 1'b0;
        end else begin
            event_o <= clash & evt_en;
            start_o <= load & ~first_seen;
            if (!en)       first_seen <= 1'b0;
            else if (load) first_seen <= 1'b1;
        end
    end

    // R5: a stalled output keeps its contents.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !load |=> valid && $stable(data) && $stable(overrun));

    // R7: a collision is presented flagged.
    assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> valid && overrun);

    // R8: an event only accompanies a flagged character.
    assert_event_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> overrun && valid);

    // R11: the start pulse coincides with a presented character.
    assert_start_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> valid);
endmodule

// File: rtl/serial_char_rx.sv
// Module: serial_char_rx (top)
// Transparent serial character receiver. An edge detector, a shifter and a
// holding register form a two-character-deep receive path. Assumes bit_clk
// and rx_bit are synchronous to clk.
module serial_char_rx
    import serial_char_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_clk,
    input  logic              rx_bit,
    input  logic              rx_en,
    input  logic [CODE_W-1:0] len_code,
    input  logic              rev_order,
    input  logic              evt_en,
    output logic [WORD_W-1:0] out_data,
    output logic              out_overrun,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              rx_event,
    output logic              buf_start
);
    logic  sample;
    logic  char_done;
    word_t char_word;

    rx_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .bit_clk (bit_clk),
        .sample  (sample)
    );

    rx_shifter #(
        .DW       (WORD_W),
        .CW       (CODE_W),
        .MIN_CODE (MIN_CODE)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .sample   (sample),
        .bit_in   (rx_bit),
        .len_code (len_code),
        .rev      (rev_order),
        .done     (char_done),
        .word     (char_word)
    );

    rx_hold #(
        .DW (WORD_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .evt_en    (evt_en),
        .load      (char_done),
        .load_word (char_word),
        .ready     (out_ready),
        .data      (out_data),
        .overrun   (out_overrun),
        .valid     (out_valid),
        .event_o   (rx_event),
        .start_o   (buf_start)
    );

    // R8: with events disabled no event appears.
    assert_event_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_en && !$past(evt_en) |-> !rx_event);
endmodule

// File: tb/serial_char_rx_tb.sv
module serial_char_rx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_en = 1'b0;
    logic [3:0]  len_code = 4'd7;
    logic        rev_order = 1'b0;
    logic        evt_en = 1'b0;
    logic [15:0] out_data;
    logic        out_overrun;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        rx_event;
    logic        buf_start;

    int total = 0;
    int bad = 0;
    int ev_cnt = 0;
    int st_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_char_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .rx_bit(rx_bit),
        .rx_en(rx_en), .len_code(len_code), .rev_order(rev_order),
        .evt_en(evt_en), .out_data(out_data), .out_overrun(out_overrun),
        .out_valid(out_valid), .out_ready(out_ready), .rx_event(rx_event),
        .buf_start(buf_start)
    );

    // Pulse counters for the event and start outputs.
    always @(posedge clk) begin
        if (rst_n && rx_event)  ev_cnt++;
        if (rst_n && buf_start) st_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; bit_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); bit_clk = 1'b0;
        @(negedge clk);
    endtask

    // Sends bits first..last of v; length L, order per rev_order.
    task automatic send_bits(input int L, input logic [15:0] v, input int from, input int upto);
        for (int i = from; i < upto; i++)
            send_bit(rev_order ? v[L-1-i] : v[i]);
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 50 && !out_valid; k++) @(negedge clk);
    endtask

    task automatic take(input logic [15:0] exp, input logic exp_ov, input string req);
        wait_valid();
        check(out_valid === 1'b1, req, int'(out_valid), 1);
        check(out_data === exp, req, int'(out_data), int'(exp));
        check(out_overrun === exp_ov, req, int'(out_overrun), int'(exp_ov));
        out_ready = 1'b1;
        @(negedge clk); out_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] pats [3];
        logic [15:0] mask;
        int ev0;
        pats[0] = 16'hFFFF; pats[1] = 16'hA5C3; pats[2] = 16'h5A3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(out_valid === 1'b0, "R5 reset valid", int'(out_valid), 0);
        check(out_data === 16'h0, "R2 reset data", int'(out_data), 0);
        check(rx_event === 1'b0 && buf_start === 1'b0, "R8 reset pulses", int'(rx_event), 0);

        // R11: first character after enable pulses buf_start
        rx_en = 1'b1; len_code = 4'd7; rev_order = 1'b0;
        send_bits(8, 16'h5C, 0, 8);
        take(16'h005C, 1'b0, "R3 first char");
        check(st_cnt == 1, "R11 first start", st_cnt, 1);

        // Sweep: R1 lengths, R3/R4 orders, R2 padding
        for (int n = 3; n <= 15; n++) begin
            for (int r = 0; r < 2; r++) begin
                for (int p = 0; p < 3; p++) begin
                    len_code = 4'(n); rev_order = r[0];
                    mask = 16'hFFFF >> (15 - n);
                    send_bits(n + 1, pats[p], 0, n + 1);
                    take(pats[p] & mask, 1'b0, r ? "R1 R2 R4 sweep" : "R1 R2 R3 sweep");
                end
            end
        end
        check(st_cnt == 1, "R11 single start", st_cnt, 1);

        // R1: clamped code 1 -> 4 bits
        len_code = 4'd1; rev_order = 1'b0;
        send_bits(4, 16'h000B, 0, 4);
        take(16'h000B, 1'b0, "R1 clamp");
        len_code = 4'd0; rev_order = 1'b1;
        send_bits(4, 16'h000B, 0, 4);
        take(16'h000B, 1'b0, "R1 clamp rev");

        // R5: stall keeps data
        len_code = 4'd7; rev_order = 1'b0;
        send_bits(8, 16'h96, 0, 8);
        wait_valid();
        repeat (6) @(negedge clk);
        take(16'h0096, 1'b0, "R5 stall");

        // R6: read held char while the next one assembles
        send_bits(8, 16'h3E, 0, 8);
        send_bits(8, 16'hC1, 0, 7);
        take(16'h003E, 1'b0, "R6 first");
        send_bits(8, 16'hC1, 7, 8);
        take(16'h00C1, 1'b0, "R6 second");

        // R7/R8: overrun with event enabled
        evt_en = 1'b1; ev0 = ev_cnt;
        send_bits(8, 16'h11, 0, 8);
        send_bits(8, 16'h22, 0, 8);
        take(16'h0022, 1'b1, "R7 overwrite");
        check(ev_cnt == ev0 + 1, "R8 event on", ev_cnt, ev0 + 1);
        // R9: continues normally
        send_bits(8, 16'h33, 0, 8);
        take(16'h0033, 1'b0, "R9 resume");
        // R8: overrun with events disabled
        evt_en = 1'b0; ev0 = ev_cnt;
        send_bits(8, 16'h44, 0, 8);
        send_bits(8, 16'h55, 0, 8);
        take(16'h0055, 1'b1, "R7 overwrite 2");
        check(ev_cnt == ev0, "R8 event off", ev_cnt, ev0);

        // R10: partial discarded by disable; R11 start again
        send_bits(8, 16'hFF, 0, 5);
        @(negedge clk); rx_en = 1'b0;
        send_bit(1'b1);
        check(out_valid === 1'b0, "R10 no output", int'(out_valid), 0);
        @(negedge clk); rx_en = 1'b1;
        send_bits(8, 16'hA5, 0, 8);
        take(16'h00A5, 1'b0, "R10 restart");
        check(st_cnt == 2, "R11 re-enable start", st_cnt, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule